// File: doc/BRIEF.md
# PCMCIA card strobe generator

This block drives the control side of one PC card socket. A host access request carries its kind (common memory, attribute memory or I/O), direction, size, the socket's configured port width, a 3-bit window mode, the host address and a transfer-size bit. On a request the block registers the socket address, attribute-select level and card enable pattern. It holds them for a programmable number of clocks and pulses exactly one read/write strobe inside that window.

The enable pattern is normally decoded from the port width, the access size and the address LSB. In window mode 110 the two enables instead copy two host address bits, which suits IDE/ATA devices. While the socket is idle the attribute-select pin carries the transfer-size bit. A 16-bit access on an 8-bit port runs as a single even-byte cycle. All socket control pins are active low.

Top module: `pccard_strobe_gen`

## Requirements
- R1: The host address `addr_i` is indexed so that `addr_i[i]` is host bit 31-i, with `addr_i[0]` as the LSB. While an access runs, `sock_addr_o[25:1]` equals `addr_i[25:1]` as captured at the request, and it stays stable until the enables are released.
- R2: During an access `attr_no` is 0 when `kind_i` is 1 (attribute) or 2 (I/O), and 1 when `kind_i` is 0 (common memory). While idle, `attr_no` follows `tsiz0_i`.
- R3: With `mode_i` other than 3'b110 and `port16_i`=0, an access drives `ce1_no`=0 and `ce2_no`=1. `sock_addr_o[0]` is 0 when `size_i`=1 (16-bit) and `addr_i[0]` when `size_i`=0 (byte).
- R4: With `mode_i` other than 3'b110 and `port16_i`=1, the outputs depend on the access. A 16-bit access gives `ce1_no`=0, `ce2_no`=0 and A0=0. An odd byte (`addr_i[0]`=1) gives `ce1_no`=1, `ce2_no`=0 and A0=1. An even byte gives `ce1_no`=0, `ce2_no`=1 and A0=0.
- R5: With `mode_i`=3'b110, `ce2_no` equals `addr_i[9]` (host bit 22) and `ce1_no` equals `addr_i[8]` (host bit 23). A0 equals `addr_i[0]`, and port width and size have no effect.
- R6: Both enables are high out of reset, while idle, and in the first cycle after every access, including in mode 110.
- R7: The strobes map as follows: a memory read drives `oe_no`, a memory write drives `we_no`, an I/O read drives `iord_no` and an I/O write drives `iowr_no` (`write_i`=1 means write). At most one strobe is low at a time. No strobe goes low while both enables are high.
- R8: Take L = max(`len_i`, 3). The enables are low for L cycles, starting the cycle after `req_i` is sampled high. The strobe is low in the second through the (L-1)th of those cycles: it starts one clock after the address and ends one clock before the enables rise.
- R9: `done_o` is high for exactly one cycle, the first cycle in which the enables are released.
- R10: A request that arrives while an access is running is ignored. The address, enables and timing of the running access are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled while idle |
| kind_i | input | 2 | 0 common memory, 1 attribute memory, 2 I/O |
| write_i | input | 1 | 1 write, 0 read |
| size_i | input | 1 | 1 16-bit access, 0 byte access |
| port16_i | input | 1 | 1 16-bit card port, 0 8-bit |
| mode_i | input | 3 | Window mode; 3'b110 selects address-copy enables |
| addr_i | input | 26 | Host address, bit 0 = host LSB |
| tsiz0_i | input | 1 | Transfer-size bit shown on attr_no while idle |
| len_i | input | 4 | Access length in clocks (minimum 3) |
| sock_addr_o | output | 26 | Socket address A25..A0 |
| attr_no | output | 1 | Attribute/I/O space select, active low |
| ce1_no | output | 1 | Even-byte card enable, active low |
| ce2_no | output | 1 | Odd-byte card enable, active low |
| oe_no | output | 1 | Memory read strobe, active low |
| we_no | output | 1 | Memory write strobe, active low |
| iord_no | output | 1 | I/O read strobe, active low |
| iowr_no | output | 1 | I/O write strobe, active low |
| done_o | output | 1 | One-cycle pulse when enables are released |

## Verification
The assertions check these rules on every cycle:
- at most one strobe is low, and none is low while both enables are high;
- an I/O strobe is always accompanied by attribute select;
- address and enables stay stable inside an access;
- the strobe only ever follows a cycle with an enable already low;
- `done_o` appears with both enables high, one cycle after the strobes have risen.

The enable truth table for every mode, width, size and byte lane, the exact cycle counts for each length, the clamping of short lengths, the idle tracking of `tsiz0_i` and the rejection of a request during an access can only be shown by the bench's sweeps against values it computes itself.

// File: rtl/pccard_pkg.sv
package pccard_pkg;
  localparam logic [2:0] IDE_MODE = 3'b110;

  typedef enum logic [1:0] {
    KIND_COMMON = 2'd0,
    KIND_ATTR   = 2'd1,
    KIND_IO     = 2'd2,
    KIND_RSVD   = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic ce1_n;
    logic ce2_n;
    logic a0;
  } ce_dec_t;

  // strobe index = {is_io, write}
  localparam int unsigned STRB_N = 4;
endpackage

// File: rtl/pccard_ce_decode.sv
module pccard_ce_decode
  import pccard_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic       port16_i,
  input  logic       half_i,
  input  logic       addr_lo_i,
  input  logic       ide_ce1_i,
  input  logic       ide_ce2_i,
  output ce_dec_t    dec_o
);
  always_comb begin
    dec_o = '{ce1_n: 1'b1, ce2_n: 1'b1, a0: addr_lo_i};
    if (mode_i == IDE_MODE) begin
      dec_o.ce1_n = ide_ce1_i;
      dec_o.ce2_n = ide_ce2_i;
      dec_o.a0    = addr_lo_i;
    end else if (!port16_i) begin
      // 8-bit port: everything on the even lane, 16-bit folds to even byte
      dec_o.ce1_n = 1'b0;
      dec_o.ce2_n = 1'b1;
      dec_o.a0    = half_i ? 1'b0 : addr_lo_i;
    end else if (half_i) begin
      dec_o.ce1_n = 1'b0;
      dec_o.ce2_n = 1'b0;
      dec_o.a0    = 1'b0;
    end else if (addr_lo_i) begin
      dec_o.ce1_n = 1'b1;
      dec_o.ce2_n = 1'b0;
      dec_o.a0    = 1'b1;
    end else begin
      dec_o.ce1_n = 1'b0;
      dec_o.ce2_n = 1'b1;
      dec_o.a0    = 1'b0;
    end
  end
endmodule

// File: rtl/pccard_seq.sv
module pccard_seq #(
  parameter int unsigned LEN_W   = 4,
  parameter int unsigned MIN_LEN = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             start_o,
  output logic             active_o,
  output logic             strobe_en_o,
  output logic             done_o
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

  logic             active_q, done_q;
  logic [LEN_W-1:0] phase_q, last_q;
  logic [LEN_W-1:0] len_eff;
  logic             at_last;

  assign len_eff = (len_i < MIN_L) ? MIN_L : len_i;
  assign start_o = req_i && !active_q;
  assign at_last = phase_q == last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= '0;
      last_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= active_q && at_last;
      if (start_o) begin
        active_q <= 1'b1;
        phase_q  <= '0;
        last_q   <= len_eff - 1'b1;
      end else if (active_q) begin
        if (at_last) active_q <= 1'b0;
        else         phase_q  <= phase_q + 1'b1;
      end
    end
  end

  // strobe sits one clock inside the enable window on both sides
  assign active_o    = active_q;
  assign strobe_en_o = active_q && (phase_q != '0) && !at_last;
  assign done_o      = done_q;
endmodule

// File: rtl/pccard_strobe_sel.sv
module pccard_strobe_sel
  import pccard_pkg::*;
(
  input  logic              fire_i,
  input  logic              is_io_i,
  input  logic              write_i,
  output logic [STRB_N-1:0] strb_n_o
);
  logic [1:0] sel;
  assign sel = {is_io_i, write_i};

  for (genvar g = 0; g < STRB_N; g++) begin : g_strb
    assign strb_n_o[g] = !(fire_i && (sel == 2'(g)));
  end
endmodule

// File: rtl/pccard_strobe_gen.sv
module pccard_strobe_gen
  import pccard_pkg::*;
#(
  parameter int unsigned ADDR_W  = 26,
  parameter int unsigned LEN_W   = 4,
  parameter int unsigned MIN_LEN = 3,
  parameter int unsigned IDE_CE1_BIT = 8,
  parameter int unsigned IDE_CE2_BIT = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        kind_i,
  input  logic              write_i,
  input  logic              size_i,
  input  logic              port16_i,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tsiz0_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] sock_addr_o,
  output logic              attr_no,
  output logic              ce1_no,
  output logic              ce2_no,
  output logic              oe_no,
  output logic              we_no,
  output logic              iord_no,
  output logic              iowr_no,
  output logic              done_o
);
  logic              start, active, strobe_en;
  ce_dec_t           dec_d, dec_q;
  logic [ADDR_W-1:1] addr_hi_q;
  logic              is_io_q, is_reg_q, write_q;
  logic [STRB_N-1:0] strb_n;
  acc_kind_e         kind;

  assign kind = acc_kind_e'(kind_i);

  pccard_ce_decode u_dec (
    .mode_i    (mode_i),
    .port16_i  (port16_i),
    .half_i    (size_i),
    .addr_lo_i (addr_i[0]),
    .ide_ce1_i (addr_i[IDE_CE1_BIT]),
    .ide_ce2_i (addr_i[IDE_CE2_BIT]),
    .dec_o     (dec_d)
  );

  pccard_seq #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .len_i       (len_i),
    .start_o     (start),
    .active_o    (active),
    .strobe_en_o (strobe_en),
    .done_o      (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_hi_q <= '0;
      dec_q     <= '{ce1_n: 1'b1, ce2_n: 1'b1, a0: 1'b0};
      is_io_q   <= 1'b0;
      is_reg_q  <= 1'b0;
      write_q   <= 1'b0;
    end else if (start) begin
      addr_hi_q <= addr_i[ADDR_W-1:1];
      dec_q     <= dec_d;
      is_io_q   <= kind == KIND_IO;
      is_reg_q  <= (kind == KIND_ATTR) || (kind == KIND_IO);
      write_q   <= write_i;
    end
  end

  // no strobe when the window selects neither lane
  pccard_strobe_sel u_sel (
    .fire_i   (strobe_en && !(dec_q.ce1_n && dec_q.ce2_n)),
    .is_io_i  (is_io_q),
    .write_i  (write_q),
    .strb_n_o (strb_n)
  );

  assign sock_addr_o = {addr_hi_q, dec_q.a0};
  assign ce1_no      = active ? dec_q.ce1_n : 1'b1;
  assign ce2_no      = active ? dec_q.ce2_n : 1'b1;
  assign attr_no     = active ? !is_reg_q : tsiz0_i;
  assign oe_no       = strb_n[0];
  assign we_no       = strb_n[1];
  assign iord_no     = strb_n[2];
  assign iowr_no     = strb_n[3];
endmodule

// File: rtl/pccard_strobe_gen_chk.sv
module pccard_strobe_gen_chk #(
  parameter int unsigned ADDR_W = 26
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] sock_addr_o,
  input logic              attr_no,
  input logic              ce1_no,
  input logic              ce2_no,
  input logic              oe_no,
  input logic              we_no,
  input logic              iord_no,
  input logic              iowr_no,
  input logic              done_o
);
  logic ce_low, strb_low;
  logic [3:0] strb_vec;
  assign strb_vec = {~oe_no, ~we_no, ~iord_no, ~iowr_no};
  assign ce_low   = !ce1_no || !ce2_no;
  assign strb_low = |strb_vec;

  p_one_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(strb_vec) <= 1);

  p_strobe_needs_ce_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_low |-> ce_low);

  p_io_with_attr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iord_no || !iowr_no) |-> !attr_no);

  p_hold_stable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_low && $past(ce_low)) |-> ($stable(sock_addr_o) && $stable(ce1_no) && $stable(ce2_no)));

  p_strobe_after_ce_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_low |-> $past(ce_low));

  p_done_released_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ce1_no && ce2_no && !strb_low));

  p_done_after_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(strb_vec == 4'b0000));

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind pccard_strobe_gen pccard_strobe_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sock_addr_o (sock_addr_o),
  .attr_no     (attr_no),
  .ce1_no      (ce1_no),
  .ce2_no      (ce2_no),
  .oe_no       (oe_no),
  .we_no       (we_no),
  .iord_no     (iord_no),
  .iowr_no     (iowr_no),
  .done_o      (done_o)
);

// File: tb/pccard_strobe_gen_test.sv
module pccard_strobe_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  kind_i = '0;
  logic        write_i = 1'b0;
  logic        size_i = 1'b0;
  logic        port16_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [25:0] addr_i = '0;
  logic        tsiz0_i = 1'b0;
  logic [3:0]  len_i = '0;
  logic [25:0] sock_addr_o;
  logic        attr_no, ce1_no, ce2_no, oe_no, we_no, iord_no, iowr_no, done_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk_i = ~clk_i;

  pccard_strobe_gen uut (.*);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // expected {ce2_n, ce1_n, a0}; encodings per R3, R4, R5
  function automatic logic [2:0] exp_lane(input logic [2:0] m, input logic p16, input logic half, input logic [25:0] a);
    if (m == 3'b110) return {a[9], a[8], a[0]};
    if (!p16)        return {1'b1, 1'b0, half ? 1'b0 : a[0]};
    if (half)        return 3'b000;
    return {~a[0], a[0], a[0]};
  endfunction

  task automatic run_access(input logic [1:0] kind, input logic wr, input logic half, input logic p16,
                            input logic [2:0] m, input logic [25:0] a, input logic [3:0] len,
                            input logic ts, input logic poke);
    int l;
    logic [2:0] ln;
    logic [3:0] strb_exp;
    string tag;
    bit act;
    l  = (len < 3) ? 3 : int'(len);
    ln = exp_lane(m, p16, half, a);
    tag = (m == 3'b110) ? "R5" : (p16 ? "R4" : "R3");
    @(negedge clk_i);
    kind_i = kind; write_i = wr; size_i = half; port16_i = p16;
    mode_i = m; addr_i = a; len_i = len; tsiz0_i = ts; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    for (int k = 0; k <= l; k++) begin
      act = k < l;
      if (act) begin
        chk(tag, "ce2_no", 32'(ce2_no), 32'(ln[2]));
        chk(tag, "ce1_no", 32'(ce1_no), 32'(ln[1]));
        chk(tag, "sock a0", 32'(sock_addr_o[0]), 32'(ln[0]));
        chk("R1", "sock addr hi", 32'(sock_addr_o[25:1]), 32'(a[25:1]));
        chk("R2", "attr active", 32'(attr_no), 32'(kind == 2'd0));
      end else begin
        chk("R6", "ce released", 32'({ce2_no, ce1_no}), 32'(2'b11));
        chk("R2", "attr idle", 32'(attr_no), 32'(ts));
      end
      strb_exp = 4'b1111;
      if (act && k >= 1 && k <= l - 2 && ln[2:1] != 2'b11)
        strb_exp[{kind == 2'd2, wr}] = 1'b0;
      chk((k == 1 || k == l - 1) ? "R8" : "R7", "strobes {iowr,iord,we,oe}",
          32'({iowr_no, iord_no, we_no, oe_no}), 32'(strb_exp));
      chk("R9", "done", 32'(done_o), 32'(k == l));
      if (poke && k == 0) begin
        req_i = 1'b1; addr_i = ~a; mode_i = ~m; port16_i = ~p16; len_i = 4'd15;
      end
      if (poke && k == 1) req_i = 1'b0;
      if (poke && k == 2) chk("R10", "addr kept", 32'(sock_addr_o), 32'({a[25:1], ln[0]}));
      if (k < l) @(negedge clk_i);
    end
    if (poke) begin
      @(negedge clk_i);
      chk("R10", "no restart ce", 32'({ce2_no, ce1_no}), 32'(2'b11));
    end
  endtask

  initial begin
    int it;
    logic [25:0] a;
    it = 0;
    repeat (3) @(negedge clk_i);
    chk("R6", "reset ce", 32'({ce2_no, ce1_no}), 32'(2'b11));
    chk("R7", "reset strobes", 32'({iowr_no, iord_no, we_no, oe_no}), 32'hF);
    chk("R9", "reset done", 32'(done_o), 32'd0);
    tsiz0_i = 1'b1; #1;
    chk("R2", "reset attr follows tsiz", 32'(attr_no), 32'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    tsiz0_i = 1'b0; #1;
    chk("R2", "idle attr follows tsiz", 32'(attr_no), 32'd0);

    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 2; p++)
        for (int h = 0; h < 2; h++)
          for (int lsb = 0; lsb < 2; lsb++)
            for (int kd = 0; kd < 3; kd++)
              for (int w = 0; w < 2; w++) begin
                a = 26'(it * 32'h0013_57A3);
                a[0] = lsb[0];
                a[9:8] = 2'(it + kd + w);
                run_access(2'(kd), w[0], h[0], p[0], 3'(m), a, 4'(it % 16),
                           it[1], (it % 7) == 3);
                it++;
              end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule